// File: doc/BRIEF.md
# Endian-Switchable Load/Store Byte Aligner

This block sits between a 32-bit register datapath and a data memory that is 32 bits wide and addressed by byte. On a store it takes the low-order item of the source register and steers each byte onto the memory lane its byte address selects. It also raises the write enables of only those lanes. On a load it collects the addressed bytes from the returned memory word, puts them in order, and zero- or sign-extends them to a full 32-bit result. A runtime input picks little-endian or big-endian byte order for each request.

Requests are taken only while the block is idle. A store finishes in the cycle it is presented, because write data and enables are combinational. A load moves the control FSM from `IDLE` to `WAIT_RD`, and the block records the order, size, signedness and byte lane of that request. When the memory signals returned data, the FSM moves to `RESULT` and registers the aligned value. In `RESULT` the block holds `ld_valid` high for one cycle and then returns to `IDLE`. The block checks alignment against the access size. A request that is not aligned raises `misalign` and has no effect on memory or on the FSM.

FSM states and transitions: `IDLE` → `WAIT_RD` when an aligned load is accepted. `WAIT_RD` → `RESULT` when `mem_rvalid` is high. `RESULT` → `IDLE` always. `IDLE` stays in `IDLE` on stores, on misaligned requests and when no request is present.

Top module: `lsa_endian_aligner`

## Requirements
- R1: Memory byte lane k is data bits 8k+7:8k and is selected by address bits 1:0 equal to k. A byte store (`req_size` = 2'b00) drives `req_wdata[7:0]` onto lane `req_addr[1:0]` and sets only that bit of `mem_be`, in both byte orders.
- R2: With `req_big_endian` = 0, a halfword store (2'b01) or word store (2'b10) puts the least significant source byte on the lane of the address and each more significant byte on the next higher lane. Example: word 0x04050607 at lane 0 gives lanes 0..3 = 07,06,05,04.
- R3: With `req_big_endian` = 1, a halfword or word store puts the most significant byte of the item on the lane of the address and the rest on the following lanes. Example: 0x04050607 as a word gives lanes 0..3 = 04,05,06,07, and as a halfword at lane 0 gives lane 0 = 06, lane 1 = 07.
- R4: A halfword with address bit 0 set, a word with address bits 1:0 nonzero, and size code 2'b11 are misaligned. For these, `misalign` is high in the request cycle, `mem_be` is zero, and no load result is produced.
- R5: With little-endian order, a load returns the byte at the address in bits 7:0 and higher-addressed bytes above it. With lanes 0..3 = AA,BB,CC,DD this gives 0x000000AA, 0x0000BBAA and 0xDDCCBBAA for byte, halfword and word.
- R6: With big-endian order, a load returns the byte at the address as the most significant byte of the item. The same memory gives 0x000000AA, 0x0000AABB and 0xAABBCCDD.
- R7: A load always sets all 32 result bits. With `req_signed` = 0 the bits above the item are zero. With `req_signed` = 1 they copy the item's top bit.
- R8: `ld_valid` is high for exactly one cycle, in the cycle after the cycle where `mem_rvalid` is seen while a load is pending. `ld_data` carries the result in that cycle.
- R9: Byte order, size, signedness and lane of a load are taken from the request cycle. Changes to these inputs while the load is pending do not affect the result.
- R10: `req_ready` is low from the cycle after a load is accepted until the FSM is back in `IDLE`. Requests presented meanwhile give no write enables and no `misalign`.
- R11: After reset `req_ready` is 1, `ld_valid` is 0 and `ld_data` is zero.
- R12: A request with `req_write` = 0 never raises any write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| req_signed | input | 1 | Load extension: 1 sign, 0 zero |
| req_big_endian | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Source register for stores |
| req_ready | output | 1 | Block is idle and takes requests |
| mem_wdata | output | DATA_W | Lane-steered store data |
| mem_be | output | DATA_W/8 | Per-lane write enables |
| misalign | output | 1 | Accepted request is misaligned or illegal |
| mem_rvalid | input | 1 | Read word is present on mem_rdata |
| mem_rdata | input | DATA_W | Memory read word |
| ld_valid | output | 1 | One-cycle load result strobe |
| ld_data | output | DATA_W | Aligned, extended load result |

## Verification
If the FSM is stuck in `WAIT_RD` or `RESULT`, `req_ready` stays low and later stores show no enables one cycle later. A FSM that leaves `RESULT` late shows a second `ld_valid` cycle, which the scoreboard sees as an unexpected result. A corrupted captured context (order, size, sign or lane) shows only in the registered `ld_data` one cycle after `mem_rvalid`. The bench therefore changes the request inputs while each load is pending. A wrong lane mapping shows at once in `mem_wdata`/`mem_be` during the store's own request cycle.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_RD,
        ST_RESULT
    } lsa_state_e;

    // number of bytes an access of the given size covers (0 for illegal)
    function automatic logic [2:0] size_bytes(acc_size_e s);
        logic [2:0] n;
        unique case (s)
            SZ_BYTE: n = 3'd1;
            SZ_HALF: n = 3'd2;
            SZ_WORD: n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
    import lsa_pkg::*;
#(
    parameter int LANES = 4
) (
    input  acc_size_e                   size,
    input  logic [$clog2(LANES)-1:0]    lane,
    output logic                        bad
);
    localparam int OFF_W = $clog2(LANES);

    always_comb begin
        unique case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = lane[0];
            SZ_WORD: bad = (lane != OFF_W'(0));
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_store_packer.sv
module lsa_store_packer #(
    parameter int LANES = 4
) (
    input  logic                        big,
    input  logic [2:0]                  nbytes,
    input  logic [$clog2(LANES)-1:0]    lane,
    input  logic [8*LANES-1:0]          src,
    output logic [8*LANES-1:0]          data,
    output logic [LANES-1:0]            be
);
    localparam int OFF_W = $clog2(LANES);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFF_W-1:0] pos;   // byte position of this lane within the item
        logic [OFF_W-1:0] pick;  // source byte (0 = least significant) for this lane
        logic [7:0]       byte_v;
        logic             en;

        always_comb begin
            pos  = OFF_W'(k) - lane;
            pick = big ? (OFF_W'(nbytes - 3'd1) - pos) : pos;
            en   = (int'(pos) < int'(nbytes));
            byte_v = 8'h00;
            for (int j = 0; j < LANES; j++) begin
                if (OFF_W'(j) == pick) byte_v = src[8*j +: 8];
            end
        end

        assign data[8*k +: 8] = byte_v;
        assign be[k]          = en;
    end
endmodule

// File: rtl/lsa_load_unpacker.sv
module lsa_load_unpacker #(
    parameter int LANES = 4
) (
    input  logic                        big,
    input  logic [2:0]                  nbytes,
    input  logic                        sgn,
    input  logic [$clog2(LANES)-1:0]    lane,
    input  logic [8*LANES-1:0]          rd,
    output logic [8*LANES-1:0]          res
);
    localparam int OFF_W = $clog2(LANES);

    logic [8*LANES-1:0] raw;
    logic [2:0]         nb_eff;
    logic               fill;

    assign nb_eff = (nbytes == 3'd0) ? 3'd1 : nbytes;

    for (genvar i = 0; i < LANES; i++) begin : g_item
        logic [OFF_W-1:0] src_lane;
        logic [7:0]       byte_v;

        always_comb begin
            src_lane = big ? (lane + OFF_W'(nb_eff - 3'd1) - OFF_W'(i))
                           : (lane + OFF_W'(i));
            byte_v = 8'h00;
            for (int j = 0; j < LANES; j++) begin
                if (OFF_W'(j) == src_lane) byte_v = rd[8*j +: 8];
            end
        end

        assign raw[8*i +: 8] = byte_v;
    end

    always_comb begin
        fill = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            if (j == int'(nb_eff) - 1) fill = sgn & raw[8*j + 7];
        end
        for (int j = 0; j < LANES; j++) begin
            res[8*j +: 8] = (j < int'(nb_eff)) ? raw[8*j +: 8] : {8{fill}};
        end
    end
endmodule

// File: rtl/lsa_endian_aligner.sv
module lsa_endian_aligner
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic                  req_signed,
    input  logic                  req_big_endian,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic                  misalign,
    input  logic                  mem_rvalid,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  ld_valid,
    output logic [DATA_W-1:0]     ld_data
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    lsa_state_e          state_q, state_d;
    logic                ctx_big_q, ctx_sgn_q;
    acc_size_e           ctx_size_q;
    logic [OFF_W-1:0]    ctx_lane_q;
    logic [DATA_W-1:0]   ld_data_q;

    acc_size_e           size_in;
    logic [OFF_W-1:0]    lane_in;
    logic                bad, accept, store_go, load_go, capture;
    logic [DATA_W-1:0]   pack_data, unpack_res;
    logic [LANES-1:0]    pack_be;

    assign size_in = acc_size_e'(req_size);
    assign lane_in = req_addr[OFF_W-1:0];

    lsa_align_check #(.LANES(LANES)) u_align (
        .size (size_in),
        .lane (lane_in),
        .bad  (bad)
    );

    lsa_store_packer #(.LANES(LANES)) u_pack (
        .big    (req_big_endian),
        .nbytes (size_bytes(size_in)),
        .lane   (lane_in),
        .src    (req_wdata),
        .data   (pack_data),
        .be     (pack_be)
    );

    lsa_load_unpacker #(.LANES(LANES)) u_unpack (
        .big    (ctx_big_q),
        .nbytes (size_bytes(ctx_size_q)),
        .sgn    (ctx_sgn_q),
        .lane   (ctx_lane_q),
        .rd     (mem_rdata),
        .res    (unpack_res)
    );

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign store_go = accept && req_write && !bad;
    assign load_go  = accept && !req_write && !bad;
    assign capture  = (state_q == ST_WAIT_RD) && mem_rvalid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (load_go) state_d = ST_WAIT_RD;
            ST_WAIT_RD: if (mem_rvalid) state_d = ST_RESULT;
            ST_RESULT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request context and load result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_big_q  <= 1'b0;
            ctx_sgn_q  <= 1'b0;
            ctx_size_q <= SZ_BYTE;
            ctx_lane_q <= '0;
            ld_data_q  <= '0;
        end else begin
            if (load_go) begin
                ctx_big_q  <= req_big_endian;
                ctx_sgn_q  <= req_signed;
                ctx_size_q <= size_in;
                ctx_lane_q <= lane_in;
            end
            if (capture) ld_data_q <= unpack_res;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        ld_valid  = (state_q == ST_RESULT);
        ld_data   = ld_data_q;
        misalign  = accept && bad;
        mem_wdata = pack_data;
        mem_be    = store_go ? pack_be : '0;
    end
endmodule

// File: rtl/lsa_endian_aligner_chk.sv
module lsa_endian_aligner_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic                  req_ready,
    input  logic [DATA_W/8-1:0]   mem_be,
    input  logic                  misalign,
    input  logic                  mem_rvalid,
    input  logic                  ld_valid
);
    // R4
    misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == '0));

    // R8
    ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R8
    ld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($past(mem_rvalid) && !$past(req_ready)));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (mem_be == '0 && !misalign));

    // R12
    load_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_write |-> (mem_be == '0));

    // R1, R2, R3
    be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_ready && !misalign) |->
            ($countones(mem_be) == ((req_size == 2'b00) ? 1 : (req_size == 2'b01) ? 2 : 4)));
endmodule

bind lsa_endian_aligner lsa_endian_aligner_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/lsa_endian_aligner_tb.sv
`timescale 1ns/1ps
module lsa_endian_aligner_tb;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_signed = 0, req_big_endian = 0;
    logic [1:0] req_size = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, misalign, ld_valid;
    logic [DATA_W-1:0] mem_wdata, ld_data;
    logic [3:0] mem_be;
    logic mem_rvalid = 0;
    logic [DATA_W-1:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    lsa_endian_aligner #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_big_endian(req_big_endian),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .misalign(misalign),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic int nb_of(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    // reference: memory byte a+i receives item byte i (LE) or byte n-1-i (BE)
    function automatic logic [35:0] ref_store(input bit big, input int nb, input int a, input logic [31:0] d);
        logic [31:0] wd = '0;
        logic [3:0]  be = '0;
        for (int i = 0; i < nb; i++) begin
            int ln = (a + i) % 4;
            wd[8*ln +: 8] = big ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
            be[ln] = 1'b1;
        end
        return {be, wd};
    endfunction

    function automatic logic [31:0] ref_load(input bit big, input int nb, input bit sg, input int a, input logic [31:0] w);
        logic [31:0] v = '0;
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b = w[8*((a + i) % 4) +: 8];
            if (big) v = (v << 8) | {24'h0, b};
            else     v = v | ({24'h0, b} << (8*i));
        end
        if (sg && v[8*nb-1]) for (int k = 8*nb; k < 32; k++) v[k] = 1'b1;
        return v;
    endfunction

    task automatic do_store(input bit big, input logic [1:0] sz, input int a, input logic [31:0] d, input string tag);
        logic [35:0] r;
        logic [31:0] mask;
        r = ref_store(big, nb_of(sz), a, d);
        for (int k = 0; k < 4; k++) mask[8*k +: 8] = {8{r[32+k]}};
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = sz; req_big_endian = big;
        req_addr = ADDR_W'(a); req_wdata = d; req_signed = 0;
        #1;
        check(mem_be == r[35:32], {tag, " be"}, {28'h0, mem_be}, {28'h0, r[35:32]});
        check((mem_wdata & mask) == r[31:0], {tag, " data"}, mem_wdata & mask, r[31:0]);
        check(!misalign, {tag, " misalign"}, {31'h0, misalign}, 32'h0);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_bad(input bit wr, input logic [1:0] sz, input int a, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; req_addr = ADDR_W'(a);
        req_wdata = 32'hFFFF_FFFF; req_big_endian = 0;
        #1;
        check(misalign, {tag, " R4 misalign"}, {31'h0, misalign}, 32'h1);
        check(mem_be == 4'h0, {tag, " R4 be"}, {28'h0, mem_be}, 32'h0);
        @(negedge clk);
        req_valid = 0;
        #1;
        check(req_ready, {tag, " R4 stays idle"}, {31'h0, req_ready}, 32'h1);
    endtask

    // load; disturb=1 changes request inputs and tries a store while pending
    task automatic do_load(input bit big, input logic [1:0] sz, input bit sg, input int a,
                           input logic [31:0] w, input int gap, input bit disturb, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_size = sz; req_big_endian = big;
        req_signed = sg; req_addr = ADDR_W'(a); req_wdata = 32'h1234_5678;
        #1;
        check(mem_be == 4'h0, {tag, " R12 load be"}, {28'h0, mem_be}, 32'h0);
        exp_q.push_back(ref_load(big, nb_of(sz), sg, a, w));
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 0;
        #1;
        check(!req_ready, {tag, " R10 busy"}, {31'h0, req_ready}, 32'h0);
        if (disturb) begin
            req_valid = 1; req_write = 1; req_big_endian = ~big; req_signed = ~sg;
            req_size = 2'b10; req_addr = '0;
            #1;
            check(mem_be == 4'h0, {tag, " R10 ignored store"}, {28'h0, mem_be}, 32'h0);
            check(!misalign, {tag, " R10 no misalign"}, {31'h0, misalign}, 32'h0);
        end
        for (int g = 0; g < gap; g++) @(negedge clk);
        mem_rvalid = 1; mem_rdata = w;
        @(negedge clk);
        mem_rvalid = 0; mem_rdata = ~w;
        req_valid = 0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check(req_ready, {tag, " R8 back idle"}, {31'h0, req_ready}, 32'h1);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && ld_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected ld_valid", ld_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(ld_data == e, t, ld_data, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #12;
        check(req_ready, "R11 ready in reset", {31'h0, req_ready}, 32'h1);
        check(!ld_valid, "R11 ld_valid in reset", {31'h0, ld_valid}, 32'h0);
        check(ld_data == 0, "R11 ld_data in reset", ld_data, 32'h0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        // R1 byte stores on every lane, both orders
        for (int k = 0; k < 4; k++) begin
            do_store(0, 2'b00, k, 32'hA5A5_A507 + 32'(k), "R1 byte le");
            do_store(1, 2'b00, k, 32'h5A5A_5A17 + 32'(k), "R1 byte be");
        end
        // R2 little-endian
        do_store(0, 2'b10, 0, 32'h0405_0607, "R2 word le");
        do_store(0, 2'b01, 0, 32'hFFFF_0607, "R2 half le lane0");
        do_store(0, 2'b01, 2, 32'h0000_C3D4, "R2 half le lane2");
        // R3 big-endian
        do_store(1, 2'b10, 0, 32'h0405_0607, "R3 word be");
        do_store(1, 2'b01, 0, 32'h0405_0607, "R3 half be lane0");
        do_store(1, 2'b01, 2, 32'h0000_C3D4, "R3 half be lane2");
        // R4 misaligned / illegal
        do_bad(1, 2'b01, 1, "half@1 store");
        do_bad(1, 2'b10, 2, "word@2 store");
        do_bad(1, 2'b11, 0, "size11 store");
        do_bad(0, 2'b10, 3, "word@3 load");
        do_bad(0, 2'b01, 3, "half@3 load");
        // R5 little-endian loads
        do_load(0, 2'b00, 0, 0, 32'hDDCC_BBAA, 0, 0, "R5 byte le");
        do_load(0, 2'b01, 0, 0, 32'hDDCC_BBAA, 1, 0, "R5 half le");
        do_load(0, 2'b10, 0, 0, 32'hDDCC_BBAA, 2, 0, "R5 word le");
        do_load(0, 2'b01, 0, 2, 32'hDDCC_BBAA, 0, 0, "R5 half le lane2");
        // R6 big-endian loads
        do_load(1, 2'b00, 0, 0, 32'hDDCC_BBAA, 0, 0, "R6 byte be");
        do_load(1, 2'b01, 0, 0, 32'hDDCC_BBAA, 0, 0, "R6 half be");
        do_load(1, 2'b10, 0, 0, 32'hDDCC_BBAA, 3, 0, "R6 word be");
        do_load(1, 2'b01, 0, 2, 32'hDDCC_BBAA, 0, 0, "R6 half be lane2");
        // R7 extension
        do_load(0, 2'b00, 1, 3, 32'h8011_2233, 0, 0, "R7 signed byte neg");
        do_load(0, 2'b00, 1, 1, 32'h8011_2233, 0, 0, "R7 signed byte pos");
        do_load(1, 2'b01, 1, 0, 32'h0000_0080, 0, 0, "R7 signed half neg be");
        do_load(0, 2'b01, 1, 2, 32'h7FFF_FFFF, 0, 0, "R7 signed half pos le");
        do_load(0, 2'b01, 0, 2, 32'h80FF_0000, 0, 0, "R7 unsigned half");
        do_load(1, 2'b10, 1, 0, 32'h0000_0080, 0, 0, "R7 signed word");
        // R9 / R10 disturbed loads
        do_load(1, 2'b01, 1, 2, 32'h1122_80FE, 2, 1, "R9 be half signed held");
        do_load(0, 2'b00, 0, 1, 32'hFFFF_9900, 1, 1, "R9 le byte unsigned held");
        // store right after a load: block accepts again
        do_store(1, 2'b10, 0, 32'hCAFE_F00D, "R10 store after load");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all loads returned", 32'(exp_q.size()), 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule